// File: doc/BRIEF.md
# Parallel NOR Flash Write Engine

This block sits on the host side of an 8-bit parallel NOR flash with a 17-bit address bus. It takes byte-program, sector-erase and chip-erase requests on a valid/ready port. It then drives the flash pins to write the unlock command bytes in the order the device expects. Every write is a WE-strobed cycle whose setup, pulse and hold lengths are set by clock-count parameters. After the last command byte, the engine waits for the internal operation to finish. It either polls the device with read cycles or runs a fixed wait. At the end it raises a one-cycle done strobe, with an error qualifier if the operation timed out.

A parameter chooses how completion is detected. In data-poll mode, bit 7 of each read is compared with the bit 7 the device will hold once the operation has finished. In toggle mode, bit 6 of two reads in a row is compared; while the device is busy it flips on every read. In timer mode the engine waits out the full time limit and makes no reads. The time limits are given in microseconds for each operation and are scaled to cycles by a clock-frequency parameter. The data bus uses separate in and out lanes with an output-enable, so a pad ring or a bench can merge them.

States: IDLE (ready) → W_SETUP → W_PULSE → W_HOLD, repeated for each command byte; then either R_PULSE ↔ R_EVAL (polling) or T_WAIT (timer); then DONE or FAIL, and back to IDLE. Named transitions: *accept* (IDLE→W_SETUP), *strobe* (W_SETUP→W_PULSE), *release* (W_PULSE→W_HOLD), *next byte* (W_HOLD→W_SETUP), *start poll* (W_HOLD→R_PULSE), *start wait* (W_HOLD→T_WAIT), *sample* (R_PULSE→R_EVAL), *repoll* (R_EVAL→R_PULSE), *finish* (R_EVAL or T_WAIT→DONE), *expire* (R_EVAL→FAIL), *retire* (DONE/FAIL→IDLE).

Top module: `nor_wr_engine`

## Requirements
- R1: After reset and while idle, req_ready is 1, flash_ce_n, flash_we_n and flash_oe_n are 1, flash_dq_oe is 0 and op_done is 0.
- R2: req_op 0 (byte program) issues exactly four writes, in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then req_data to req_addr.
- R3: req_op 2 (chip erase) issues exactly six writes, in this order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h.
- R4: req_op 1 (sector erase) issues the first five chip-erase writes, then 30h to req_addr with its low 12 bits cleared (4 KB sectors).
- R5: Each write takes SETUP_CYC cycles with CE low and WE high, then PULSE_CYC cycles with WE low, then HOLD_CYC cycles with WE high. The bus drives dq_oe throughout, and address and data do not change while WE is low.
- R6: In data-poll mode (DONE_MODE 0), each read keeps OE low for READ_CYC cycles and is followed by one cycle with OE high. The operation completes on the first read whose bit 7 equals bit 7 of req_data (program) or 1 (erase).
- R7: In toggle mode (DONE_MODE 1), the operation completes on the first read whose bit 6 equals bit 6 of the read just before it. The first read of an operation never completes it.
- R8: In timer mode (DONE_MODE 2), no read cycles occur, and op_done rises exactly the time limit in cycles after the last write.
- R9: If polling has not completed when the time limit (PROG_US, SECT_US or CHIP_US times CLK_MHZ cycles, counted from the first read cycle) is reached at an evaluation, op_done pulses with op_err 1.
- R10: op_done is a one-cycle pulse. With T = SETUP_CYC+PULSE_CYC+HOLD_CYC, W writes and n reads, it is high in cycle W·T + n·(READ_CYC+1) after the accepting edge. req_ready is 0 from the accepting edge until op_done.
- R11: req_op 3 is consumed while idle but causes no write, no read and no op_done.
- R12: During a read, CE and OE are low, WE is high, dq_oe is 0, and flash_addr is req_addr. WE and OE are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| req_addr | input | 17 | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| op_done | output | 1 | One-cycle completion strobe |
| op_err | output | 1 | Set with op_done when the time limit expired |
| flash_addr | output | 17 | Flash address pins |
| flash_dout | output | 8 | Data driven toward the flash |
| flash_dq_oe | output | 1 | Enable for flash_dout onto the data pins |
| flash_din | input | 8 | Data read from the flash pins |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
op_done is due exactly W·T + n·(READ_CYC+1) cycles after the accepting edge for a polled operation, and W·T plus the time limit for timer mode. n is worked out in the bench from the number of busy reads the flash model gives and the bit values it returns. The bench counts falling clock edges from the accepting edge and compares the count against that figure. It checks that op_done is low again one cycle later. The write sequence is checked as a running signature of address/data pairs, captured on each rising WE edge. The read count is checked against n, and the last WE low width against PULSE_CYC.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } nor_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_PULSE,
        ST_W_HOLD,
        ST_R_PULSE,
        ST_R_EVAL,
        ST_T_WAIT,
        ST_DONE,
        ST_FAIL
    } nor_st_e;

    localparam int MODE_DATA   = 0;
    localparam int MODE_TOGGLE = 1;
    localparam int MODE_TIMER  = 2;

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
    import nor_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 12
) (
    input  nor_op_e             op,
    input  logic [2:0]          step,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [DATA_W-1:0]   tgt_data,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0]   cmd_data,
    output logic                cmd_last
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(16'h5555);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(16'h2AAA);
    localparam logic [ADDR_W-1:0] SECT_BASE_MASK = ~((ADDR_W'(1) << SECT_BITS) - ADDR_W'(1));

    always_comb begin
        cmd_addr = A_HI;
        cmd_data = DATA_W'(8'hAA);
        if (op == OP_SECT || op == OP_CHIP) begin
            cmd_last = (step == 3'd5);
            unique case (step)
                3'd0, 3'd3: begin cmd_addr = A_HI; cmd_data = DATA_W'(8'hAA); end
                3'd1, 3'd4: begin cmd_addr = A_LO; cmd_data = DATA_W'(8'h55); end
                3'd2:       begin cmd_addr = A_HI; cmd_data = DATA_W'(8'h80); end
                default: begin
                    if (op == OP_CHIP) begin
                        cmd_addr = A_HI;
                        cmd_data = DATA_W'(8'h10);
                    end else begin
                        cmd_addr = tgt_addr & SECT_BASE_MASK;
                        cmd_data = DATA_W'(8'h30);
                    end
                end
            endcase
        end else begin
            cmd_last = (step == 3'd3);
            unique case (step)
                3'd0:    begin cmd_addr = A_HI; cmd_data = DATA_W'(8'hAA); end
                3'd1:    begin cmd_addr = A_LO; cmd_data = DATA_W'(8'h55); end
                3'd2:    begin cmd_addr = A_HI; cmd_data = DATA_W'(8'hA0); end
                default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
            endcase
        end
    end
endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval
    import nor_pkg::*;
#(
    parameter int MODE = MODE_DATA
) (
    input  logic is_erase,
    input  logic data7,
    input  logic now7,
    input  logic now6,
    input  logic prev6,
    input  logic prev_ok,
    output logic complete
);
    logic unused_ok;
    assign unused_ok = ^{is_erase, data7, now7, now6, prev6, prev_ok};

    if (MODE == MODE_TOGGLE) begin : g_toggle
        assign complete = prev_ok && (now6 == prev6);
    end else if (MODE == MODE_DATA) begin : g_data
        assign complete = (now7 == (is_erase ? 1'b1 : data7));
    end else begin : g_timer
        assign complete = 1'b0;
    end
endmodule

// File: rtl/nor_timeout.sv
module nor_timeout #(
    parameter int TO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] tcnt_q;

    assign expired = run && (tcnt_q >= limit - TO_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tcnt_q <= '0;
        else if (!run)    tcnt_q <= '0;
        else if (!expired) tcnt_q <= tcnt_q + TO_W'(1);
    end
endmodule

// File: rtl/nor_wr_engine.sv
module nor_wr_engine
    import nor_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 12,
    parameter int CLK_MHZ   = 50,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2,
    parameter int READ_CYC  = 3,
    parameter int DONE_MODE = MODE_DATA,
    parameter int PROG_US   = 20,
    parameter int SECT_US   = 25000,
    parameter int CHIP_US   = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              op_done,
    output logic              op_err,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dout,
    output logic              flash_dq_oe,
    input  logic [DATA_W-1:0] flash_din,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n
);
    localparam int CNT_W = 8;
    localparam int TO_W  = 32;
    localparam logic [TO_W-1:0] LIM_PROG = TO_W'(PROG_US * CLK_MHZ);
    localparam logic [TO_W-1:0] LIM_SECT = TO_W'(SECT_US * CLK_MHZ);
    localparam logic [TO_W-1:0] LIM_CHIP = TO_W'(CHIP_US * CLK_MHZ);

    nor_st_e             state_q, state_d;
    nor_op_e             op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [2:0]          step_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    phase_len;
    logic                phase_end;
    logic [1:0]          rd_q;
    logic                prev6_q, got_q, prev_ok_q;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [DATA_W-1:0]   cmd_data;
    logic                cmd_last;
    logic                complete, expired, to_run;
    logic [TO_W-1:0]     limit;
    logic                unused_din;

    assign unused_din = ^flash_din;

    nor_cmd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_cmd (
        .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last)
    );

    nor_poll_eval #(.MODE(DONE_MODE)) u_eval (
        .is_erase(op_q != OP_PROG), .data7(data_q[DATA_W-1]),
        .now7(rd_q[1]), .now6(rd_q[0]), .prev6(prev6_q), .prev_ok(prev_ok_q),
        .complete(complete)
    );

    assign to_run = (state_q == ST_R_PULSE) || (state_q == ST_R_EVAL) || (state_q == ST_T_WAIT);

    always_comb begin
        unique case (op_q)
            OP_SECT: limit = LIM_SECT;
            OP_CHIP: limit = LIM_CHIP;
            default: limit = LIM_PROG;
        endcase
    end

    nor_timeout #(.TO_W(TO_W)) u_to (
        .clk(clk), .rst_n(rst_n), .run(to_run), .limit(limit), .expired(expired)
    );

    always_comb begin
        unique case (state_q)
            ST_W_SETUP: phase_len = CNT_W'(SETUP_CYC);
            ST_W_PULSE: phase_len = CNT_W'(PULSE_CYC);
            ST_W_HOLD:  phase_len = CNT_W'(HOLD_CYC);
            default:    phase_len = CNT_W'(READ_CYC);
        endcase
        phase_end = (cnt_q == phase_len - CNT_W'(1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid && req_op != 2'(OP_NONE)) state_d = ST_W_SETUP;
            ST_W_SETUP: if (phase_end) state_d = ST_W_PULSE;
            ST_W_PULSE: if (phase_end) state_d = ST_W_HOLD;
            ST_W_HOLD: begin
                if (phase_end) begin
                    if (!cmd_last)                    state_d = ST_W_SETUP;
                    else if (DONE_MODE == MODE_TIMER) state_d = ST_T_WAIT;
                    else                              state_d = ST_R_PULSE;
                end
            end
            ST_R_PULSE: if (phase_end) state_d = ST_R_EVAL;
            ST_R_EVAL: begin
                if (complete)     state_d = ST_DONE;
                else if (expired) state_d = ST_FAIL;
                else              state_d = ST_R_PULSE;
            end
            ST_T_WAIT:  if (expired) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAIL:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q || state_q == ST_IDLE) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // request and read-sample registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_PROG;
            addr_q    <= '0;
            data_q    <= '0;
            step_q    <= '0;
            rd_q      <= '0;
            prev6_q   <= 1'b0;
            got_q     <= 1'b0;
            prev_ok_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q      <= nor_op_e'(req_op);
                addr_q    <= req_addr;
                data_q    <= req_data;
                step_q    <= '0;
                got_q     <= 1'b0;
                prev_ok_q <= 1'b0;
            end
            if (state_q == ST_W_HOLD && phase_end && !cmd_last) step_q <= step_q + 3'd1;
            if (state_q == ST_R_PULSE && phase_end) begin
                rd_q      <= {flash_din[DATA_W-1], flash_din[DATA_W-2]};
                prev6_q   <= rd_q[0];
                prev_ok_q <= got_q;
                got_q     <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        op_done     = 1'b0;
        op_err      = 1'b0;
        flash_ce_n  = 1'b1;
        flash_oe_n  = 1'b1;
        flash_we_n  = 1'b1;
        flash_dq_oe = 1'b0;
        flash_addr  = cmd_addr;
        flash_dout  = cmd_data;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_W_SETUP, ST_W_HOLD: begin
                flash_ce_n  = 1'b0;
                flash_dq_oe = 1'b1;
            end
            ST_W_PULSE: begin
                flash_ce_n  = 1'b0;
                flash_dq_oe = 1'b1;
                flash_we_n  = 1'b0;
            end
            ST_R_PULSE: begin
                flash_ce_n = 1'b0;
                flash_oe_n = 1'b0;
                flash_addr = addr_q;
            end
            ST_R_EVAL: begin
                flash_ce_n = 1'b0;
                flash_addr = addr_q;
            end
            ST_DONE: op_done = 1'b1;
            ST_FAIL: begin
                op_done = 1'b1;
                op_err  = 1'b1;
            end
            default: ;
        endcase
    end

    assert_we_oe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));
    assert_read_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> (!flash_ce_n && !flash_dq_oe && flash_addr == addr_q));
    assert_we_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (!flash_ce_n && flash_dq_oe));
    assert_we_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dout)));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && !flash_dq_oe && !op_done));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_done);
    assert_timer_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (DONE_MODE == MODE_TIMER) |-> flash_oe_n);
endmodule

// File: tb/nor_wr_engine_tb.sv
`timescale 1ns/1ps

module nor_flash_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [16:0] flash_addr,
    input  logic [7:0]  flash_dout,
    input  logic        flash_ce_n,
    input  logic        flash_oe_n,
    input  logic        flash_we_n,
    input  int          busy_n,
    input  int          rd_base,
    input  logic [7:0]  true_val,
    output logic [7:0]  flash_din,
    output logic [63:0] sig,
    output int          wr_cnt,
    output int          rd_cnt,
    output int          we_width,
    output logic [16:0] rd_addr
);
    int k;
    int low_run = 0;
    initial begin sig = '0; wr_cnt = 0; rd_cnt = 0; we_width = 0; rd_addr = '0; end

    always_comb begin
        k = rd_cnt - rd_base;
        flash_din = (k < busy_n) ? {~true_val[7], k[0], true_val[5:0]} : true_val;
    end

    always @(posedge flash_we_n) if (rst_n && !flash_ce_n) begin
        sig    <= sig * 64'd31 + {39'd0, flash_addr, flash_dout};
        wr_cnt <= wr_cnt + 1;
    end

    always @(posedge flash_oe_n) if (rst_n) rd_cnt <= rd_cnt + 1;

    always @(negedge clk) begin
        if (!flash_we_n) low_run <= low_run + 1;
        else if (low_run != 0) begin we_width <= low_run; low_run <= 0; end
        if (!flash_oe_n) rd_addr <= flash_addr;
    end
endmodule

module nor_wr_engine_tb;
    localparam int S = 1, P = 2, H = 1, R = 2, T = S + P + H;
    localparam int LIM_P = 20, LIM_S = 40, LIM_C = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid [3];
    logic        req_ready [3];
    logic [1:0]  req_op    [3];
    logic [16:0] req_addr  [3];
    logic [7:0]  req_data  [3];
    logic        op_done   [3];
    logic        op_err    [3];
    logic [16:0] f_addr    [3];
    logic [7:0]  f_dout    [3];
    logic        f_dq_oe   [3];
    logic [7:0]  f_din     [3];
    logic        f_ce_n    [3];
    logic        f_oe_n    [3];
    logic        f_we_n    [3];
    int          busy_n    [3];
    int          rd_base   [3];
    logic [7:0]  true_val  [3];
    logic [63:0] sig       [3];
    int          wr_cnt    [3];
    int          rd_cnt    [3];
    int          we_width  [3];
    logic [16:0] rd_addr   [3];

    for (genvar g = 0; g < 3; g++) begin : gen_mode
        nor_wr_engine #(
            .CLK_MHZ(1), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .READ_CYC(R),
            .DONE_MODE(g), .PROG_US(LIM_P), .SECT_US(LIM_S), .CHIP_US(LIM_C)
        ) u_dut (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[g]), .req_ready(req_ready[g]), .req_op(req_op[g]),
            .req_addr(req_addr[g]), .req_data(req_data[g]),
            .op_done(op_done[g]), .op_err(op_err[g]),
            .flash_addr(f_addr[g]), .flash_dout(f_dout[g]), .flash_dq_oe(f_dq_oe[g]),
            .flash_din(f_din[g]), .flash_ce_n(f_ce_n[g]), .flash_oe_n(f_oe_n[g]),
            .flash_we_n(f_we_n[g])
        );
        nor_flash_model u_flash (
            .clk(clk), .rst_n(rst_n), .flash_addr(f_addr[g]), .flash_dout(f_dout[g]),
            .flash_ce_n(f_ce_n[g]), .flash_oe_n(f_oe_n[g]), .flash_we_n(f_we_n[g]),
            .busy_n(busy_n[g]), .rd_base(rd_base[g]), .true_val(true_val[g]),
            .flash_din(f_din[g]), .sig(sig[g]), .wr_cnt(wr_cnt[g]), .rd_cnt(rd_cnt[g]),
            .we_width(we_width[g]), .rd_addr(rd_addr[g])
        );
    end

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sstep(input logic [63:0] s, input logic [16:0] a, input logic [7:0] d);
        return s * 64'd31 + {39'd0, a, d};
    endfunction

    task automatic run_op(input int m, input int op, input logic [16:0] a, input logic [7:0] d,
                          input int busy, input bit expect_to);
        int w, nreads, nexp, lim, cyc, wc0, rc0;
        logic [63:0] esig;
        logic [7:0] tv;
        bit seen, errv;
        string rw, rr;
        tv   = (op == 0) ? d : 8'hFF;
        w    = (op == 0) ? 4 : 6;
        lim  = (op == 0) ? LIM_P : (op == 1) ? LIM_S : LIM_C;
        esig = sig[m]; wc0 = wr_cnt[m]; rc0 = rd_cnt[m];
        esig = sstep(esig, 17'h5555, 8'hAA);
        esig = sstep(esig, 17'h2AAA, 8'h55);
        if (op == 0) begin
            esig = sstep(esig, 17'h5555, 8'hA0);
            esig = sstep(esig, a, d);
            rw = "R2";
        end else begin
            esig = sstep(esig, 17'h5555, 8'h80);
            esig = sstep(esig, 17'h5555, 8'hAA);
            esig = sstep(esig, 17'h2AAA, 8'h55);
            if (op == 2) begin esig = sstep(esig, 17'h5555, 8'h10); rw = "R3"; end
            else begin esig = sstep(esig, {a[16:12], 12'h000}, 8'h30); rw = "R4"; end
        end
        if (m == 2) begin
            nreads = 0; nexp = w * T + lim; rr = "R8";
        end else begin
            if (expect_to) begin nreads = (lim + R) / (R + 1); rr = "R9"; end
            else if (m == 0) begin nreads = busy + 1; rr = "R6"; end
            else begin
                rr = "R7";
                if (busy == 0) nreads = 2;
                else nreads = (((busy - 1) & 1) == int'(tv[6])) ? busy + 1 : busy + 2;
            end
            nexp = w * T + nreads * (R + 1);
        end
        busy_n[m] = busy; rd_base[m] = rc0; true_val[m] = tv;
        @(negedge clk);
        req_valid[m] = 1'b1; req_op[m] = 2'(op); req_addr[m] = a; req_data[m] = d;
        @(negedge clk);
        req_valid[m] = 1'b0;
        check(req_ready[m] == 1'b0, "R10 ready low while busy", req_ready[m], 0);
        cyc = 0; seen = 0; errv = 0;
        while (cyc < 3000 && !seen) begin
            if (op_done[m]) begin seen = 1; errv = op_err[m]; end
            else begin cyc++; @(negedge clk); end
        end
        check(seen && cyc == nexp, {rr, " R10 done latency"}, cyc, nexp);
        check(errv == expect_to, {"R9 error flag"}, errv, expect_to);
        check(wr_cnt[m] - wc0 == w, {rw, " write count"}, wr_cnt[m] - wc0, w);
        check(sig[m] == esig, {rw, " write sequence signature"}, sig[m], esig);
        check(rd_cnt[m] - rc0 == nreads, {rr, " read count"}, rd_cnt[m] - rc0, nreads);
        check(we_width[m] == P, "R5 WE low width", we_width[m], P);
        if (m != 2)
            check(rd_addr[m] == a, "R12 read address", rd_addr[m], a);
        @(negedge clk);
        check(op_done[m] == 1'b0, "R10 done single cycle", op_done[m], 0);
        check(req_ready[m] == 1'b1, "R1 idle after done", req_ready[m], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 3; m++) begin
            req_valid[m] = 0; req_op[m] = 0; req_addr[m] = '0; req_data[m] = '0;
            busy_n[m] = 0; rd_base[m] = 0; true_val[m] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 3; m++)
            check(req_ready[m] && f_ce_n[m] && f_we_n[m] && f_oe_n[m] && !f_dq_oe[m] && !op_done[m],
                  "R1 reset state", {req_ready[m], f_ce_n[m], f_we_n[m], f_oe_n[m], f_dq_oe[m], op_done[m]},
                  6'b111100);

        for (int m = 0; m < 3; m++)
            for (int op = 0; op < 3; op++)
                for (int b = 0; b < 4; b++)
                    run_op(m, op, 17'h0ABCD ^ 17'(op << 13) ^ 17'(b * 17'h111),
                           8'h5A + 8'(37 * b) + 8'(11 * op), b, 1'b0);

        run_op(0, 0, 17'h01234, 8'h80, 1000, 1'b1);
        run_op(1, 0, 17'h04321, 8'h40, 1000, 1'b1);
        run_op(0, 2, 17'h1F000, 8'h00, 1000, 1'b1);
        run_op(1, 1, 17'h13579, 8'h00, 1000, 1'b1);

        for (int m = 0; m < 3; m++) begin : r11_ignore
            int wc0, rc0;
            bit any_done;
            wc0 = wr_cnt[m]; rc0 = rd_cnt[m]; any_done = 0;
            @(negedge clk);
            req_valid[m] = 1'b1; req_op[m] = 2'd3;
            @(negedge clk);
            req_valid[m] = 1'b0;
            for (int i = 0; i < 40; i++) begin
                if (op_done[m] || !f_ce_n[m]) any_done = 1;
                @(negedge clk);
            end
            check(!any_done && wr_cnt[m] == wc0 && rd_cnt[m] == rc0 && req_ready[m],
                  "R11 op 3 ignored", wr_cnt[m] - wc0 + rd_cnt[m] - rc0 + int'(any_done), 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule